// File: doc/BRIEF.md
# Super Power Save Sequencer

An always-powered sequencer that owns the enable of a machine's main supply rails. After reset it turns the rails on and keeps the machine's I/O port disabled. It enables the port only once an I/O controller has raised two acknowledge lines. While the port is enabled, an idle indication from the I/O controller lights a power-save LED and arms a reserved state, provided automatic entry is selected. A later acknowledge from the I/O controller confirms that the idle period has run out, and the sequencer then drops the rails. A rising edge on a power-save key drops the rails at once, without waiting for the idle period.

While the rails are off, a wake request or a key press turns them back on. The port is then held disabled until the acknowledge handshake completes again. A saturating counter measures how long the handshake has been waiting and raises an error flag when the limit is reached. Every asynchronous input passes through a two-flop synchronizer. The key is edge-detected, so one press causes exactly one transition.

Top module: `pwr_save_seq`

## Requirements
- R1: While rst_ni is low, rail_en_o is 0, port_dis_o is 1 and led_no is 1. On the first clock edge after reset release, rail_en_o goes to 1.
- R2: With the rails on after reset or wake, port_dis_o stays 1 until ack_i and nack_i are both seen high through the synchronizer. It goes to 0 on the next edge after that.
- R3: While the port is enabled and auto_i is 1, idle_ni low moves the block to the reserved state, with led_no 0 and rail_en_o 1.
- R4: While auto_i is 0, idle_ni low has no effect: led_no stays 1 and rail_en_o stays 1.
- R5: In the reserved state, ack_i high drops rail_en_o to 0 and sets port_dis_o to 1, while led_no stays 0.
- R6: In the reserved state, idle_ni returning high or auto_i falling to 0 returns the block to normal operation with led_no 1.
- R7: A rising edge of key_i in normal operation or in the reserved state drops the rails directly, with led_no 0.
- R8: A key held high causes only one transition. Key edges during the handshake wait have no effect.
- R9: With the rails off, wake_i high or a key rising edge sets rail_en_o to 1 with port_dis_o 1 and led_no 1, and the block waits for the handshake again.
- R10: hs_err_o goes to 1 after HS_TIMEOUT clock cycles spent waiting for the handshake. It returns to 0 when the handshake completes.
- R11: Every input reaches the state logic two clock edges after it is sampled. The state changes on the third edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | First acknowledge from the I/O controller; also confirms idle timeout |
| nack_i | input | 1 | Second acknowledge from the I/O controller |
| idle_ni | input | 1 | Idle indication, active low |
| key_i | input | 1 | Power-save key, level |
| wake_i | input | 1 | External wake request |
| auto_i | input | 1 | 1 selects automatic entry on idle |
| rail_en_o | output | 1 | Main rail enable |
| port_dis_o | output | 1 | Port disable, 1 = disabled |
| led_no | output | 1 | Power-save LED, active low |
| hs_err_o | output | 1 | Handshake timeout flag |

## Verification
The bench withholds the acknowledges past the timeout. A design with a wrong limit or a flag that never clears would show the flag at the wrong cycle. It drives a single acknowledge, which a design that gates the port on only one line would wrongly enable. It holds the key high across several cycles, so edge detection that re-triggers would bounce the block back out of power save. It also toggles the idle line with auto off, presses the key during the handshake wait, and lets the idle line return during the reserved state. Each of these exposes a design that ignores the mode select, acts on keys in the wrong state, or never releases the LED.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_HS    = 3'd1,
    ST_NORM  = 3'd2,
    ST_RSV   = 3'd3,
    ST_SLEEP = 3'd4
  } pss_state_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/pss_hs_timer.sv
module pss_hs_timer #(
  parameter int HS_TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_hs_i,
  output logic err_o
);
  localparam int CW = $clog2(HS_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HS_TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!in_hs_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign err_o = in_hs_i && (cnt_q == LIMIT);

  assert_err_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && in_hs_i) |=> (err_o || !in_hs_i));
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  logic       nack_i,
  input  logic       idle_ni,
  input  logic       auto_i,
  input  logic       wake_i,
  input  logic       key_pulse_i,
  output logic       in_hs_o,
  output logic       rail_en_o,
  output logic       port_dis_o,
  output logic       led_no
);
  pss_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_INIT:  st_d = ST_HS;
      ST_HS:    if (ack_i && nack_i) st_d = ST_NORM;
      ST_NORM: begin
        if (key_pulse_i)            st_d = ST_SLEEP;
        else if (auto_i && !idle_ni) st_d = ST_RSV;
      end
      ST_RSV: begin
        if (key_pulse_i || ack_i)   st_d = ST_SLEEP;
        else if (idle_ni || !auto_i) st_d = ST_NORM;
      end
      ST_SLEEP: if (key_pulse_i || wake_i) st_d = ST_HS;
      default:  st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_INIT;
    else         st_q <= st_d;
  end

  assign in_hs_o    = (st_q == ST_HS);
  assign rail_en_o  = (st_q == ST_HS) || (st_q == ST_NORM) || (st_q == ST_RSV);
  assign port_dis_o = !((st_q == ST_NORM) || (st_q == ST_RSV));
  assign led_no     = !((st_q == ST_RSV) || (st_q == ST_SLEEP));

  assert_port_en_needs_acks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(port_dis_o) && !$past(led_no == 1'b0)) |-> $past(ack_i && nack_i));
  assert_rail_drop_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rail_en_o) |-> ($past(key_pulse_i) || $past(ack_i && st_q == ST_RSV)));
  assert_led_on_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(led_no) |-> ($past(key_pulse_i) || $past(auto_i && !idle_ni)));
  assert_wake_port_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rail_en_o) && $past(st_q == ST_SLEEP)) |-> port_dis_o);
endmodule

// File: rtl/pwr_save_seq.sv
module pwr_save_seq #(
  parameter int HS_TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic nack_i,
  input  logic idle_ni,
  input  logic key_i,
  input  logic wake_i,
  input  logic auto_i,
  output logic rail_en_o,
  output logic port_dis_o,
  output logic led_no,
  output logic hs_err_o
);
  localparam int NIN = 6;
  localparam int I_ACK = 0, I_NACK = 1, I_IDLE = 2, I_KEY = 3, I_WAKE = 4, I_AUTO = 5;

  logic [NIN-1:0] raw, syn;
  logic key_d_q, key_pulse, in_hs;

  assign raw = {auto_i, wake_i, key_i, idle_ni, nack_i, ack_i};

  pss_sync #(.W(NIN)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw), .q_o (syn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_d_q <= 1'b0;
    else         key_d_q <= syn[I_KEY];
  end
  assign key_pulse = syn[I_KEY] && !key_d_q;

  pss_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (syn[I_ACK]),
    .nack_i      (syn[I_NACK]),
    .idle_ni     (syn[I_IDLE]),
    .auto_i      (syn[I_AUTO]),
    .wake_i      (syn[I_WAKE]),
    .key_pulse_i (key_pulse),
    .in_hs_o     (in_hs),
    .rail_en_o   (rail_en_o),
    .port_dis_o  (port_dis_o),
    .led_no      (led_no)
  );

  pss_hs_timer #(.HS_TIMEOUT(HS_TIMEOUT)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_hs_i (in_hs), .err_o (hs_err_o)
  );

  assert_key_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_pulse |=> !key_pulse);
  assert_err_in_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_err_o |-> (rail_en_o && port_dis_o));
endmodule

// File: tb/sim_pwr_save_seq.sv
module sim_pwr_save_seq;
  localparam int TO = 16;
  localparam int S_INIT = 0, S_HS = 1, S_NORM = 2, S_RSV = 3, S_SLEEP = 4;

  logic clk = 0, rst_n = 0;
  logic ack = 0, nack = 0, idle_n = 1, key = 0, wake = 0, auto_m = 0;
  logic rail, pdis, led_n, err;
  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  pwr_save_seq #(.HS_TIMEOUT(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ack_i(ack), .nack_i(nack), .idle_ni(idle_n),
    .key_i(key), .wake_i(wake), .auto_i(auto_m),
    .rail_en_o(rail), .port_dis_o(pdis), .led_no(led_n), .hs_err_o(err)
  );

  // reference model: history of sampled inputs, bit order {auto,wake,key,idle_n,nack,ack}
  logic [5:0] hist[$];
  int m_st, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {6'b0, 6'b0, 6'b0};
      m_st = S_INIT; m_cnt = 0;
    end else begin
      logic [5:0] h, p;
      logic kp;
      h = hist[1]; p = hist[2];   // seen two and three edges ago (R11)
      kp = h[3] && !p[3];
      if (m_st == S_HS) begin if (m_cnt < TO) m_cnt++; end
      else m_cnt = 0;
      case (m_st)
        S_INIT:  m_st = S_HS;
        S_HS:    if (h[0] && h[1]) m_st = S_NORM;
        S_NORM:  if (kp) m_st = S_SLEEP; else if (h[5] && !h[2]) m_st = S_RSV;
        S_RSV:   if (kp || h[0]) m_st = S_SLEEP; else if (h[2] || !h[5]) m_st = S_NORM;
        default: if (kp || h[4]) m_st = S_HS;
      endcase
      hist.push_front({auto_m, wake, key, idle_n, nack, ack});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic cmp();
    chk("rail_en", rail, m_st == S_HS || m_st == S_NORM || m_st == S_RSV);
    chk("port_dis", pdis, !(m_st == S_NORM || m_st == S_RSV));
    chk("led_n", led_n, !(m_st == S_RSV || m_st == S_SLEEP));
    chk("hs_err", err, m_st == S_HS && m_cnt == TO);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("rail_en in reset", rail, 1'b0);
    chk("port_dis in reset", pdis, 1'b1);
    chk("led_n in reset", led_n, 1'b1);
    rst_n = 1;
    run(2);
    chk("rail on after reset R1", rail, 1'b1);
    cur_req = "R10"; run(TO + 4);
    chk("timeout flag R10", err, 1'b1);
    cur_req = "R2"; ack = 1; run(6);
    chk("single ack keeps port off R2", pdis, 1'b1);
    nack = 1; run(2);
    chk("port still off before sync R11", pdis, 1'b1);
    run(1);
    chk("port on after both acks R2", pdis, 1'b0);
    chk("flag cleared R10", err, 1'b0);
    ack = 0; run(3);
    cur_req = "R4"; idle_n = 0; run(6);
    chk("idle ignored in manual R4", led_n, 1'b1);
    idle_n = 1; run(3);
    cur_req = "R3"; auto_m = 1; run(3); idle_n = 0; run(5);
    chk("reserved led on R3", led_n, 1'b0);
    chk("reserved rail on R3", rail, 1'b1);
    cur_req = "R6"; idle_n = 1; run(4);
    chk("led off after idle release R6", led_n, 1'b1);
    cur_req = "R6"; idle_n = 0; run(4); auto_m = 0; run(4);
    chk("auto cleared leaves reserved R6", led_n, 1'b1);
    auto_m = 1; run(4);
    cur_req = "R5"; ack = 1; run(4);
    chk("rail off R5", rail, 1'b0);
    chk("led stays on R5", led_n, 1'b0);
    ack = 0; idle_n = 1; run(4);
    cur_req = "R9"; key = 1; run(1); key = 0; run(4);
    chk("wake by key rail on R9", rail, 1'b1);
    chk("wake by key port held R9", pdis, 1'b1);
    ack = 1; run(4); ack = 0; run(3);
    chk("handshake again R9", pdis, 1'b0);
    cur_req = "R7"; key = 1; run(8);
    chk("key sleeps from normal R7", rail, 1'b0);
    cur_req = "R8"; run(6);
    chk("held key no retrigger R8", rail, 1'b0);
    key = 0; run(3);
    cur_req = "R9"; wake = 1; run(1); wake = 0; run(4);
    chk("wake_i rail on R9", rail, 1'b1);
    cur_req = "R8"; key = 1; run(2); key = 0; run(4);
    chk("key in wait ignored R8", rail, 1'b1);
    ack = 1; run(4); ack = 0; idle_n = 0; run(4);
    cur_req = "R7"; key = 1; run(4); key = 0;
    chk("key sleeps from reserved R7", rail, 1'b0);
    run(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule